// File: doc/BRIEF.md
# Programmable LVDS Lane Mapper and 7:1 Serializer

This block accepts one parallel pixel per symbol period: a red, green and blue word together with horizontal sync, vertical sync and data-valid flags. It gathers these into a fixed source vector. Every data lane owns seven output slots, and each slot carries its own 5-bit selector, so any source bit can land on any slot of any lane. The block runs on a fast bit clock. An internal phase counter divides that clock into seven-cycle symbols. Each symbol shifts one mapped 7-bit word out per lane and drives a clock lane with a fixed 4:3 duty pattern.

There are two channels, each with the same number of data lanes and one clock lane. Control inputs set the following: per-lane enables for each channel, clock-lane enables, single or dual channel operation, a channel exchange, an overall interface enable and a serializer enable that is kept separate. Software writes the lane configuration first and raises the serializer enable only after a delay. The block samples every input at the symbol boundary, so a configuration change never splits a symbol.

Top module: `lvds_lane_serializer`

## Requirements
- R1: While rst_n is low, and until the first symbol boundary after its release, every data and clock output is 0. The phase counter restarts at 0.
- R2: The source vector holds red at indices 0..COLOR_W-1, green at COLOR_W..2*COLOR_W-1 and blue at 2*COLOR_W..3*COLOR_W-1. Hsync is at index 3*COLOR_W, vsync at 3*COLOR_W+1 and data-valid at 3*COLOR_W+2. Index 3*COLOR_W+3 (27 by default) always reads 0.
- R3: Slot s of lane l is selected by map_cfg[(l*SLOTS+s)*IDX_W +: IDX_W] and carries the source bit at that index. An index above 27 yields 0.
- R4: A symbol boundary falls on every seventh rising edge, and the first one is the seventh edge after reset release. During the seven cycles that follow a boundary, each lane outputs slot 6, then 5, and so on down to slot 0, one slot per cycle.
- R5: An active clock lane outputs 1,1,0,0,0,1,1 over the seven cycles of each symbol.
- R6: A data lane whose enable bit is 0 holds 0. Enable bit c*LANES+l belongs to lane l of channel c, and clk_lane_en[c] belongs to the clock lane of channel c.
- R7: With dual_mode at 0, channel 1 (the second channel) keeps all its data and clock outputs at 0 whatever its enables are.
- R8: With dual_mode at 1, channel 1 lanes carry the same mapped bits as channel 0, each gated by its own enable.
- R9: With ch_swap at 1, the physical outputs of channel 0 carry what channel 1 would produce, and the physical outputs of channel 1 carry what channel 0 would produce.
- R10: With intf_en at 0, all outputs are 0.
- R11: With ser_en at 0, all outputs are held idle at 0 even when lanes are configured and enabled.
- R12: The block samples pixel, mapping and control inputs only at a symbol boundary. A change at any other time has no effect until the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven cycles per symbol |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_r | input | COLOR_W | Red component |
| pix_g | input | COLOR_W | Green component |
| pix_b | input | COLOR_W | Blue component |
| pix_hs | input | 1 | Horizontal sync flag |
| pix_vs | input | 1 | Vertical sync flag |
| pix_de | input | 1 | Data-valid flag |
| map_cfg | input | LANES*SLOTS*IDX_W | Slot selectors, lane-major then slot |
| lane_en | input | 2*LANES | Data lane enables, channel 0 in the low half |
| clk_lane_en | input | 2 | Clock lane enable per channel |
| dual_mode | input | 1 | 1 = both channels active |
| ch_swap | input | 1 | Exchange the two channels' outputs |
| intf_en | input | 1 | Interface enable |
| ser_en | input | 1 | Serializer enable |
| data_out | output | 2*LANES | Serial data lanes, physical channel 0 in the low half |
| clk_out | output | 2 | Clock lane per physical channel |

## Verification
The embedded assertions check on every cycle that:
- the phase stays within one symbol;
- the latched state holds still between boundaries;
- a cleared interface or serializer enable, seen at a boundary, silences every lane for the next symbol;
- single-channel mode keeps the second channel quiet;
- clock-lane edges occur only at the pattern's phases.

The bench scenarios are needed for the rest: the actual slot-to-bit selection in both colour layouts, out-of-range selectors, MSB-first ordering, per-lane gating, dual-channel mirroring, the channel exchange, and the fact that mid-symbol changes are ignored.

// File: rtl/lvds_map_pkg.sv
package lvds_map_pkg;

    // Control fields captured once per symbol.
    typedef struct packed {
        logic       dual;
        logic       swap;
        logic       intf;
        logic       ser;
        logic [1:0] clk_en;
    } lane_ctrl_t;

    localparam int CHANNELS = 2;

endpackage

// File: rtl/lvds_src_pack.sv
// Gathers one pixel into the selectable source vector.
module lvds_src_pack #(
    parameter int COLOR_W = 8,
    parameter int SRC_N   = 3 * COLOR_W + 4
) (
    input  logic [COLOR_W-1:0] r_i,
    input  logic [COLOR_W-1:0] g_i,
    input  logic [COLOR_W-1:0] b_i,
    input  logic               hs_i,
    input  logic               vs_i,
    input  logic               de_i,
    output logic [SRC_N-1:0]   src_o
);
    // Top entry is a constant zero spare.
    assign src_o = {1'b0, de_i, vs_i, hs_i, b_i, g_i, r_i};
endmodule

// File: rtl/lvds_lane_select.sv
// One lane: every slot picks any source bit through its own selector.
module lvds_lane_select #(
    parameter int SRC_N = 28,
    parameter int SLOTS = 7,
    parameter int IDX_W = 5
) (
    input  logic [SRC_N-1:0]       src_i,
    input  logic [SLOTS*IDX_W-1:0] idx_i,
    output logic [SLOTS-1:0]       sym_o
);
    localparam int EXT_N = 1 << IDX_W;

    // Zero-extended so out-of-range selectors read 0 without a compare.
    logic [EXT_N-1:0] src_ext;
    assign src_ext = EXT_N'(src_i);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign sym_o[s] = src_ext[idx_i[s*IDX_W +: IDX_W]];
    end
endmodule

// File: rtl/lvds_lane_gate.sv
// Applies enables, channel mode and channel exchange to the current bits.
module lvds_lane_gate
    import lvds_map_pkg::*;
#(
    parameter int LANES = 4
) (
    input  lane_ctrl_t                  ctrl_i,
    input  logic [CHANNELS*LANES-1:0]   lane_en_i,
    input  logic [LANES-1:0]            bit_i,
    input  logic                        clk_bit_i,
    output logic [CHANNELS*LANES-1:0]   data_o,
    output logic [CHANNELS-1:0]         clk_o
);
    logic                      live;
    logic [CHANNELS-1:0]       ch_ok;
    logic [CHANNELS*LANES-1:0] log_data;
    logic [CHANNELS-1:0]       log_clk;

    assign live     = ctrl_i.intf & ctrl_i.ser;
    assign ch_ok[0] = live;
    assign ch_ok[1] = live & ctrl_i.dual;

    for (genvar c = 0; c < CHANNELS; c++) begin : g_log
        assign log_data[c*LANES +: LANES] =
            {LANES{ch_ok[c]}} & lane_en_i[c*LANES +: LANES] & bit_i;
        assign log_clk[c] = ch_ok[c] & ctrl_i.clk_en[c] & clk_bit_i;
    end

    for (genvar p = 0; p < CHANNELS; p++) begin : g_phys
        localparam int OTHER = CHANNELS - 1 - p;
        assign data_o[p*LANES +: LANES] = ctrl_i.swap ? log_data[OTHER*LANES +: LANES]
                                                      : log_data[p*LANES +: LANES];
        assign clk_o[p] = ctrl_i.swap ? log_clk[OTHER] : log_clk[p];
    end
endmodule

// File: rtl/lvds_lane_serializer.sv
module lvds_lane_serializer
    import lvds_map_pkg::*;
#(
    parameter int               COLOR_W = 8,
    parameter int               LANES   = 4,
    parameter int               SLOTS   = 7,
    parameter int               IDX_W   = 5,
    parameter logic [SLOTS-1:0] CLK_PAT = 7'b1100011
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [COLOR_W-1:0]            pix_r,
    input  logic [COLOR_W-1:0]            pix_g,
    input  logic [COLOR_W-1:0]            pix_b,
    input  logic                          pix_hs,
    input  logic                          pix_vs,
    input  logic                          pix_de,
    input  logic [LANES*SLOTS*IDX_W-1:0]  map_cfg,
    input  logic [2*LANES-1:0]            lane_en,
    input  logic [1:0]                    clk_lane_en,
    input  logic                          dual_mode,
    input  logic                          ch_swap,
    input  logic                          intf_en,
    input  logic                          ser_en,
    output logic [2*LANES-1:0]            data_out,
    output logic [1:0]                    clk_out
);
    localparam int SRC_N  = 3 * COLOR_W + 4;
    localparam int LANE_W = SLOTS * IDX_W;
    localparam int PH_W   = $clog2(SLOTS);
    localparam int SYM_W  = LANES * SLOTS;
    localparam logic [PH_W-1:0] LAST = PH_W'(SLOTS - 1);

    typedef struct packed {
        logic [PH_W-1:0]           ph;
        lane_ctrl_t                ctrl;
        logic [CHANNELS*LANES-1:0] lane_en;
        logic [SYM_W-1:0]          sym;
    } state_t;

    state_t state_d, state_q;

    logic [SRC_N-1:0] src_vec;
    logic [SYM_W-1:0] sel_sym;
    logic             boundary;
    logic [PH_W-1:0]  slot_sel;
    logic [LANES-1:0] cur_bit;
    logic             cur_clk;

    lvds_src_pack #(.COLOR_W(COLOR_W), .SRC_N(SRC_N)) u_pack (
        .r_i  (pix_r),
        .g_i  (pix_g),
        .b_i  (pix_b),
        .hs_i (pix_hs),
        .vs_i (pix_vs),
        .de_i (pix_de),
        .src_o(src_vec)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lvds_lane_select #(.SRC_N(SRC_N), .SLOTS(SLOTS), .IDX_W(IDX_W)) u_sel (
            .src_i(src_vec),
            .idx_i(map_cfg[l*LANE_W +: LANE_W]),
            .sym_o(sel_sym[l*SLOTS +: SLOTS])
        );
    end

    assign boundary = (state_q.ph == LAST);

    // Next-state: everything is captured at the boundary only.
    always_comb begin
        state_d = state_q;
        if (boundary) begin
            state_d.ph          = '0;
            state_d.ctrl.dual   = dual_mode;
            state_d.ctrl.swap   = ch_swap;
            state_d.ctrl.intf   = intf_en;
            state_d.ctrl.ser    = ser_en;
            state_d.ctrl.clk_en = clk_lane_en;
            state_d.lane_en     = lane_en;
            state_d.sym         = sel_sym;
        end else begin
            state_d.ph = state_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // Highest slot leaves first.
    assign slot_sel = LAST - state_q.ph;

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            cur_bit[l] = state_q.sym[l*SLOTS + int'(slot_sel)];
        end
        cur_clk = CLK_PAT[slot_sel];
    end

    lvds_lane_gate #(.LANES(LANES)) u_gate (
        .ctrl_i   (state_q.ctrl),
        .lane_en_i(state_q.lane_en),
        .bit_i    (cur_bit),
        .clk_bit_i(cur_clk),
        .data_o   (data_out),
        .clk_o    (clk_out)
    );

    // ---------------- assertions ----------------
    a_r4_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.ph <= LAST);

    a_r12_held_between_boundaries: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> ($stable(state_q.ctrl) && $stable(state_q.lane_en) && $stable(state_q.sym)));

    a_r11_idle_without_ser: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !ser_en) |=> (data_out == '0 && clk_out == '0));

    a_r10_idle_without_intf: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !intf_en) |=> (data_out == '0 && clk_out == '0));

    a_r7_single_second_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !dual_mode && !ch_swap) |=>
            (data_out[2*LANES-1:LANES] == '0 && !clk_out[1]));

    // Edge phases below hold for the default clock pattern.
    a_r5_clk_rise_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_out[0]) |-> (state_q.ph == '0 || state_q.ph == PH_W'(5)));

    a_r5_clk_fall_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_out[0]) |-> (state_q.ph == '0 || state_q.ph == PH_W'(2)));
endmodule

// File: tb/lvds_lane_serializer_bench.sv
module lvds_lane_serializer_bench;
    localparam int COLOR_W = 8;
    localparam int LANES   = 4;
    localparam int SLOTS   = 7;
    localparam int IDX_W   = 5;
    localparam int SRC_N   = 3 * COLOR_W + 4;
    localparam int MAP_W   = LANES * SLOTS * IDX_W;
    localparam int NL      = 2 * LANES;
    localparam logic [6:0] PAT = 7'b1100011;

    // Colour layouts: entry lane*7+slot.
    localparam logic [4:0] TAB24 [28] = '{
        5'h08, 5'h05, 5'h04, 5'h03, 5'h02, 5'h01, 5'h00,
        5'h11, 5'h10, 5'h0d, 5'h0c, 5'h0b, 5'h0a, 5'h09,
        5'h1a, 5'h19, 5'h18, 5'h15, 5'h14, 5'h13, 5'h12,
        5'h1b, 5'h17, 5'h16, 5'h0f, 5'h0e, 5'h07, 5'h06};
    localparam logic [4:0] TAB18 [28] = '{
        5'h0a, 5'h07, 5'h06, 5'h05, 5'h04, 5'h03, 5'h02,
        5'h13, 5'h12, 5'h0f, 5'h0e, 5'h0d, 5'h0c, 5'h0b,
        5'h1a, 5'h19, 5'h18, 5'h17, 5'h16, 5'h15, 5'h14,
        5'h1b, 5'h1b, 5'h1b, 5'h1b, 5'h1b, 5'h1b, 5'h1b};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [COLOR_W-1:0] pix_r, pix_g, pix_b;
    logic pix_hs, pix_vs, pix_de;
    logic [MAP_W-1:0] map_cfg;
    logic [NL-1:0] lane_en;
    logic [1:0] clk_lane_en;
    logic dual_mode, ch_swap, intf_en, ser_en;
    logic [NL-1:0] data_out;
    logic [1:0] clk_out;

    always #10 clk = ~clk;

    lvds_lane_serializer u_lvds_lane_serializer (
        .clk(clk), .rst_n(rst_n), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_de(pix_de), .map_cfg(map_cfg),
        .lane_en(lane_en), .clk_lane_en(clk_lane_en), .dual_mode(dual_mode),
        .ch_swap(ch_swap), .intf_en(intf_en), .ser_en(ser_en),
        .data_out(data_out), .clk_out(clk_out));

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [SRC_N-1:0] e_src;
    logic [MAP_W-1:0] e_map;
    logic [NL-1:0] e_le;
    logic [1:0] e_ce;
    logic e_dual, e_swap, e_intf, e_ser;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic map_bit(input int lane, input int slot);
        logic [4:0] idx;
        idx = e_map[(lane*SLOTS+slot)*IDX_W +: IDX_W];
        return (int'(idx) < SRC_N - 1) ? e_src[idx] : 1'b0;
    endfunction

    function automatic logic [NL-1:0] exp_data(input int k);
        logic [NL-1:0] r;
        for (int p = 0; p < 2; p++) begin
            int c;
            logic ok;
            c  = e_swap ? 1 - p : p;
            ok = e_intf & e_ser & ((c == 0) | e_dual);
            for (int l = 0; l < LANES; l++)
                r[p*LANES+l] = ok & e_le[c*LANES+l] & map_bit(l, 6 - k);
        end
        return r;
    endfunction

    function automatic logic [1:0] exp_clk(input int k);
        logic [1:0] r;
        for (int p = 0; p < 2; p++) begin
            int c;
            c = e_swap ? 1 - p : p;
            r[p] = e_intf & e_ser & ((c == 0) | e_dual) & e_ce[c] & PAT[6-k];
        end
        return r;
    endfunction

    task automatic rand_pixel();
        pix_r = COLOR_W'($urandom); pix_g = COLOR_W'($urandom); pix_b = COLOR_W'($urandom);
        pix_hs = 1'($urandom); pix_vs = 1'($urandom); pix_de = 1'($urandom);
    endtask

    task automatic rand_map();
        for (int i = 0; i < LANES*SLOTS; i++) map_cfg[i*IDX_W +: IDX_W] = IDX_W'($urandom);
    endtask

    task automatic load_table(input bit is24);
        for (int i = 0; i < LANES*SLOTS; i++)
            map_cfg[i*IDX_W +: IDX_W] = is24 ? TAB24[i] : TAB18[i];
    endtask

    task automatic set_ctrl(input logic [NL-1:0] le, input logic [1:0] ce, input logic du,
                            input logic sw, input logic ie, input logic se);
        lane_en = le; clk_lane_en = ce; dual_mode = du; ch_swap = sw; intf_en = ie; ser_en = se;
    endtask

    task automatic scramble();
        rand_pixel();
        rand_map();
        set_ctrl(NL'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    endtask

    // Entered at a negedge in the last phase of a symbol.
    task automatic run_sym(input string tag, input bit disturb);
        e_src = {1'b0, pix_de, pix_vs, pix_hs, pix_b, pix_g, pix_r};
        e_map = map_cfg; e_le = lane_en; e_ce = clk_lane_en;
        e_dual = dual_mode; e_swap = ch_swap; e_intf = intf_en; e_ser = ser_en;
        for (int k = 0; k < SLOTS; k++) begin
            @(posedge clk);
            @(negedge clk);
            check(tag, 32'(data_out), 32'(exp_data(k)));
            check("R5", 32'(clk_out), 32'(exp_clk(k)));
            if (disturb && k == 2) scramble();
        end
    endtask

    initial begin
        void'($urandom(32'h00c0ffee));
        pix_r = '0; pix_g = '0; pix_b = '0; pix_hs = 0; pix_vs = 0; pix_de = 0;
        map_cfg = '0;
        set_ctrl('0, '0, 0, 0, 0, 0);
        repeat (3) begin
            @(negedge clk);
            check("R1", 32'(data_out), 0);
            check("R1", 32'(clk_out), 0);
        end
        // Configure before release so the first boundary loads something visible.
        load_table(1'b1);
        rand_pixel();
        set_ctrl(8'h0F, 2'b01, 0, 0, 1, 1);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(posedge clk);
            @(negedge clk);
            check("R1", 32'(data_out), 0);
            check("R1", 32'(clk_out), 0);
        end

        // R2/R4: 24-bit layout, single channel, several pixels
        for (int i = 0; i < 6; i++) begin rand_pixel(); run_sym("R4", 0); end
        // R2: each flag alone on a fully selected lane 0
        for (int f = 0; f < 4; f++) begin
            pix_r = '0; pix_g = '0; pix_b = '0;
            pix_hs = (f == 0); pix_vs = (f == 1); pix_de = (f == 2);
            for (int s = 0; s < SLOTS; s++) map_cfg[s*IDX_W +: IDX_W] = IDX_W'(24 + f);
            run_sym("R2", 0);
        end
        // R3: 18-bit layout on three lanes
        load_table(1'b0);
        set_ctrl(8'h07, 2'b01, 0, 0, 1, 1);
        for (int i = 0; i < 5; i++) begin rand_pixel(); run_sym("R3", 0); end
        // R3: out-of-range selectors read 0
        for (int i = 0; i < LANES*SLOTS; i++) map_cfg[i*IDX_W +: IDX_W] = IDX_W'(28 + (i % 4));
        set_ctrl(8'h0F, 2'b01, 0, 0, 1, 1);
        pix_r = '1; pix_g = '1; pix_b = '1; pix_hs = 1; pix_vs = 1; pix_de = 1;
        run_sym("R3", 0);
        // R11: serializer disabled with full configuration
        load_table(1'b1);
        set_ctrl(8'hFF, 2'b11, 1, 0, 1, 0);
        for (int i = 0; i < 2; i++) begin rand_pixel(); run_sym("R11", 0); end
        ser_en = 1'b1; rand_pixel(); run_sym("R11", 0);
        // R10: interface disabled
        intf_en = 1'b0; rand_pixel(); run_sym("R10", 0);
        // R6: partial lane enables
        for (int i = 0; i < 6; i++) begin
            set_ctrl(NL'($urandom), 2'b01, 0, 0, 1, 1); rand_pixel(); run_sym("R6", 0);
        end
        // R7: single mode ignores channel 1 enables
        set_ctrl(8'hFF, 2'b11, 0, 0, 1, 1);
        for (int i = 0; i < 3; i++) begin rand_pixel(); run_sym("R7", 0); end
        // R8: dual mode mirrors onto channel 1
        set_ctrl(8'hFF, 2'b11, 1, 0, 1, 1);
        for (int i = 0; i < 3; i++) begin rand_pixel(); run_sym("R8", 0); end
        set_ctrl(8'h5A, 2'b10, 1, 0, 1, 1); rand_pixel(); run_sym("R8", 0);
        // R9: channel exchange, single and dual
        set_ctrl(8'h0F, 2'b01, 0, 1, 1, 1);
        for (int i = 0; i < 2; i++) begin rand_pixel(); run_sym("R9", 0); end
        set_ctrl(8'h3C, 2'b01, 1, 1, 1, 1); rand_pixel(); run_sym("R9", 0);
        // R12: mid-symbol changes have no effect
        set_ctrl(8'hFF, 2'b11, 1, 0, 1, 1);
        for (int i = 0; i < 6; i++) begin
            rand_pixel(); rand_map(); run_sym("R12", 1);
            set_ctrl(8'hFF, 2'b11, 1, 0, 1, 1);
        end
        // R3/R4: random mix
        for (int i = 0; i < 150; i++) begin
            scramble(); intf_en = 1'b1; ser_en = ($urandom % 8) != 0;
            run_sym("R3", (i % 5) == 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R4 watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule